// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block is the digital counting section of a dual-modulus frequency synthesizer. It receives one strobe per output period of an external dual-modulus prescaler and steers that prescaler through a modulus-control pin. A swallow counter and a program counter share the work. The swallow counter holds the prescaler at P+1 for the first A periods of each cycle. The program counter closes the cycle after N periods. One comparison pulse is therefore produced every P·N + A oscillator cycles. A separate reference counter divides a reference strobe by R and produces the reference pulse for the phase comparator. The loop therefore settles at f_osc_out = (P·N + A)·f_ref / R.

Settings are offered through a load strobe and checked on arrival. A legal set is held in a shadow register. The divider counters copy it only at their own cycle boundary, so a cycle in progress is never cut short or stretched. A set that breaks a range rule is refused as a whole, and the error flag reports the refusal. A pair-select bit chooses between the narrow prescaler pair (P, P+1) and a wide pair of twice that base. Like the counts, it switches at the boundary of a comparison cycle. No data stream crosses the block, so every pin is a plain control or status signal with no handshake.

Top module: `swallow_divider`

## Requirements
- R1: While reset is held and on the first cycle after it, `fp`, `fr`, `mod_plus1`, `cfg_err` and `pair_wide` are all 0. The reset settings are A=0, N=3, R=3 and the narrow pair.
- R2: `fp` goes high for exactly one clock after the N-th `pre_pulse` of a comparison cycle. With each `pre_pulse` period lasting P clocks when `mod_plus1`=0 and P+1 clocks when it is 1, consecutive `fp` pulses are P·N+A clocks apart.
- R3: `mod_plus1` is 1 during the first A prescaler periods of a cycle and 0 for the remaining N−A. With A=0 it stays 0 for the whole cycle.
- R4: `cfg_narrow`=1 selects the narrow pair, and `pair_wide` then reads 0 with P=16. `cfg_narrow`=0 selects the wide pair, and `pair_wide` then reads 1 with P=32.
- R5: `fr` goes high for one clock after every R-th `ref_tick`.
- R6: An accepted load clears `cfg_err` on the next clock. The new A, N and pair take effect only at the next comparison-cycle boundary; `pair_wide` does not change before that boundary.
- R7: A load with N<3 sets `cfg_err` to 1, and the previous A, N, R and pair stay in force.
- R8: A load with A≥N sets `cfg_err` to 1, and the previous settings stay in force.
- R9: A load with R<3 sets `cfg_err` to 1, and the reference period is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, one oscillator cycle per clock in the bench model |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_pulse | input | 1 | One-clock strobe at the end of each prescaler output period |
| ref_tick | input | 1 | One-clock strobe per reference clock period |
| cfg_load | input | 1 | Offers the settings on the cfg_* pins |
| cfg_swallow | input | 7 | Swallow count A, 0 to 127 |
| cfg_prog | input | 11 | Program count N, 3 to 2047 |
| cfg_ref | input | 14 | Reference count R, 3 to 16383 |
| cfg_narrow | input | 1 | 1 = narrow prescaler pair, 0 = wide pair |
| mod_plus1 | output | 1 | Modulus control: 1 asks the prescaler for P+1 |
| pair_wide | output | 1 | 1 when the wide prescaler pair is in force |
| fp | output | 1 | Comparison pulse, one per P·N+A oscillator cycles |
| fr | output | 1 | Reference pulse, one per R reference ticks |
| cfg_err | output | 1 | 1 after a refused load, 0 after an accepted one |

## Verification
A behavioural prescaler in the bench closes the loop: it counts P or P+1 clocks according to `mod_plus1` and the reported pair, and the spacing of `fp` pulses is compared against P·N+A. The patterns cover A=0, where any stray P+1 period adds a clock. They cover A=N−1, which catches an off-by-one in either counter. They cover large and mid-sized A with both pairs, which separates a swallow miscount from a wrong P. Refused loads are followed by a fresh interval measurement, which shows whether bad values leaked into the counters. A switch of pair loaded mid-cycle shows whether settings apply before the boundary.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int SWD_A_W   = 7;
  localparam int SWD_N_W   = 11;
  localparam int SWD_R_W   = 14;
  localparam int SWD_PAD_W = SWD_N_W - SWD_A_W;

  typedef struct packed {
    logic [SWD_A_W-1:0] swallow;
    logic [SWD_N_W-1:0] prog;
    logic [SWD_R_W-1:0] refdiv;
    logic               narrow;
  } swd_cfg_t;
endpackage

// File: rtl/swd_cfg_reg.sv
module swd_cfg_reg
  import swd_pkg::*;
#(
  parameter int MIN_DIV    = 3,
  parameter int RST_A      = 0,
  parameter int RST_N      = 3,
  parameter int RST_R      = 3,
  parameter bit RST_NARROW = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  swd_cfg_t cand,
  output swd_cfg_t held,
  output logic     err
);
  logic n_ok, r_ok, a_ok, all_ok;

  always_comb begin
    n_ok   = cand.prog >= SWD_N_W'(MIN_DIV);
    r_ok   = cand.refdiv >= SWD_R_W'(MIN_DIV);
    a_ok   = {{SWD_PAD_W{1'b0}}, cand.swallow} < cand.prog;
    all_ok = n_ok && r_ok && a_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held.swallow <= SWD_A_W'(RST_A);
      held.prog    <= SWD_N_W'(RST_N);
      held.refdiv  <= SWD_R_W'(RST_R);
      held.narrow  <= RST_NARROW;
      err          <= 1'b0;
    end else if (load) begin
      err <= !all_ok;
      if (all_ok) held <= cand;
    end
  end

  // R7 R8 R9
  refused_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !all_ok) |=> (err && $stable(held)));

  // R6
  accepted_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && all_ok) |=> !err);
endmodule

// File: rtl/swd_main_div.sv
module swd_main_div
  import swd_pkg::*;
#(
  parameter int RST_A      = 0,
  parameter int RST_N      = 3,
  parameter bit RST_NARROW = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_pulse,
  input  logic [SWD_A_W-1:0] sh_swallow,
  input  logic [SWD_N_W-1:0] sh_prog,
  input  logic               sh_narrow,
  output logic               mod_plus1,
  output logic               pair_wide,
  output logic               fp
);
  logic [SWD_A_W-1:0] a_cnt;
  logic [SWD_N_W-1:0] n_cnt;
  logic               last_period;

  assign last_period = n_cnt <= SWD_N_W'(1);
  assign mod_plus1   = a_cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cnt     <= SWD_A_W'(RST_A);
      n_cnt     <= SWD_N_W'(RST_N);
      pair_wide <= !RST_NARROW;
      fp        <= 1'b0;
    end else begin
      fp <= 1'b0;
      if (pre_pulse) begin
        if (last_period) begin
          a_cnt     <= sh_swallow;
          n_cnt     <= sh_prog;
          pair_wide <= !sh_narrow;
          fp        <= 1'b1;
        end else begin
          n_cnt <= n_cnt - SWD_N_W'(1);
          if (a_cnt != '0) a_cnt <= a_cnt - SWD_A_W'(1);
        end
      end
    end
  end

  // R2
  fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  // R2
  fp_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp |-> $past(pre_pulse));

  // R3
  mod_drop_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_plus1) |-> $past(pre_pulse));

  // R6
  pair_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair_wide) |-> fp);
endmodule

// File: rtl/swd_ref_div.sv
module swd_ref_div
  import swd_pkg::*;
#(
  parameter int RST_R = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic [SWD_R_W-1:0] sh_ref,
  output logic               fr
);
  logic [SWD_R_W-1:0] r_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_cnt <= SWD_R_W'(RST_R);
      fr    <= 1'b0;
    end else begin
      fr <= 1'b0;
      if (ref_tick) begin
        if (r_cnt <= SWD_R_W'(1)) begin
          r_cnt <= sh_ref;
          fr    <= 1'b1;
        end else begin
          r_cnt <= r_cnt - SWD_R_W'(1);
        end
      end
    end
  end

  // R5
  fr_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr |-> $past(ref_tick));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int MIN_DIV    = 3,
  parameter int RST_A      = 0,
  parameter int RST_N      = 3,
  parameter int RST_R      = 3,
  parameter bit RST_NARROW = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_pulse,
  input  logic               ref_tick,
  input  logic               cfg_load,
  input  logic [SWD_A_W-1:0] cfg_swallow,
  input  logic [SWD_N_W-1:0] cfg_prog,
  input  logic [SWD_R_W-1:0] cfg_ref,
  input  logic               cfg_narrow,
  output logic               mod_plus1,
  output logic               pair_wide,
  output logic               fp,
  output logic               fr,
  output logic               cfg_err
);
  swd_cfg_t cand, held;

  always_comb begin
    cand.swallow = cfg_swallow;
    cand.prog    = cfg_prog;
    cand.refdiv  = cfg_ref;
    cand.narrow  = cfg_narrow;
  end

  swd_cfg_reg #(
    .MIN_DIV(MIN_DIV), .RST_A(RST_A), .RST_N(RST_N),
    .RST_R(RST_R), .RST_NARROW(RST_NARROW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cand(cand),
    .held(held), .err(cfg_err)
  );

  swd_main_div #(
    .RST_A(RST_A), .RST_N(RST_N), .RST_NARROW(RST_NARROW)
  ) u_main (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse),
    .sh_swallow(held.swallow), .sh_prog(held.prog), .sh_narrow(held.narrow),
    .mod_plus1(mod_plus1), .pair_wide(pair_wide), .fp(fp)
  );

  swd_ref_div #(
    .RST_R(RST_R)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .sh_ref(held.refdiv), .fr(fr)
  );
endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
  localparam int BASE_P   = 16;
  localparam int REF_STEP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre_pulse = 1'b0;
  logic        ref_tick = 1'b0;
  logic        cfg_load = 1'b0;
  logic [6:0]  cfg_swallow = '0;
  logic [10:0] cfg_prog = 11'd3;
  logic [13:0] cfg_ref = 14'd3;
  logic        cfg_narrow = 1'b1;
  logic        mod_plus1, pair_wide, fp, fr, cfg_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int fp_cnt = 0;
  int last_fp = -1;
  int exp_q[$];
  string exp_tag[$];

  swallow_divider u_swallow_divider (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse), .ref_tick(ref_tick),
    .cfg_load(cfg_load), .cfg_swallow(cfg_swallow), .cfg_prog(cfg_prog),
    .cfg_ref(cfg_ref), .cfg_narrow(cfg_narrow), .mod_plus1(mod_plus1),
    .pair_wide(pair_wide), .fp(fp), .fr(fr), .cfg_err(cfg_err)
  );

  initial forever #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural prescaler: period of P or P+1 clocks
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cnt = 0;
        pre_pulse = 1'b0;
      end else begin
        int len;
        len = (pair_wide ? 2 * BASE_P : BASE_P) + (mod_plus1 ? 1 : 0);
        cnt++;
        if (cnt >= len) begin
          pre_pulse = 1'b1;
          cnt = 0;
        end else begin
          pre_pulse = 1'b0;
        end
      end
    end
  end

  // reference strobe every REF_STEP clocks
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % REF_STEP;
      ref_tick = rst_n && (k == 0);
    end
  end

  // monitor: fp interval scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && fp) begin
        if (last_fp >= 0 && exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          check(t, cyc - last_fp, e);
        end
        last_fp = cyc;
        fp_cnt++;
      end
    end
  end

  task automatic load_cfg(input int a, input int n, input int r, input bit nar);
    @(negedge clk);
    cfg_swallow = 7'(a);
    cfg_prog    = 11'(n);
    cfg_ref     = 14'(r);
    cfg_narrow  = nar;
    cfg_load    = 1'b1;
    @(negedge clk);
    cfg_load    = 1'b0;
  endtask

  task automatic expect_fp(input int exp, input string tag);
    int c0;
    c0 = fp_cnt;
    wait (fp_cnt >= c0 + 2);
    exp_q.push_back(exp);
    exp_tag.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  task automatic measure_fr(output int gap);
    int t0;
    do @(negedge clk); while (!fr);
    do @(negedge clk); while (!fr);
    t0 = cyc;
    do @(negedge clk); while (!fr);
    gap = cyc - t0;
  endtask

  initial begin
    int gap;
    repeat (4) @(negedge clk);
    // R1 during reset
    check("R1 fp", fp, 0);
    check("R1 mod", mod_plus1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fr", fr, 0);
    check("R1 err", cfg_err, 0);
    check("R1 pair", pair_wide, 0);

    // reset settings: 16*3+0
    expect_fp(48, "R2 reset cfg");

    load_cfg(7, 10, 5, 1'b1);
    check("R6 err clear", cfg_err, 0);
    expect_fp(16 * 10 + 7, "R2 R3 a7 n10");
    measure_fr(gap);
    check("R5 fr R=5", gap, 5 * REF_STEP);

    // mid-cycle switch to wide pair: boundary rule
    do @(negedge clk); while (!fp);
    repeat (3) @(negedge clk);
    load_cfg(19, 20, 5, 1'b0);
    @(negedge clk);
    check("R6 pair held", pair_wide, 0);
    expect_fp(32 * 20 + 19, "R4 wide a19 n20");
    check("R4 pair wide", pair_wide, 1);

    load_cfg(2, 3, 5, 1'b0);
    expect_fp(32 * 3 + 2, "R2 a=n-1");

    load_cfg(0, 3, 5, 1'b0);
    expect_fp(96, "R3 a0");
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (mod_plus1) seen++;
      end
      check("R3 mod never high", seen, 0);
    end

    load_cfg(0, 2, 5, 1'b1);
    check("R7 err", cfg_err, 1);
    expect_fp(96, "R7 kept");
    check("R7 pair kept", pair_wide, 1);

    load_cfg(5, 5, 5, 1'b1);
    check("R8 err", cfg_err, 1);
    expect_fp(96, "R8 kept");

    load_cfg(0, 3, 2, 1'b0);
    check("R9 err", cfg_err, 1);
    measure_fr(gap);
    check("R9 fr kept", gap, 5 * REF_STEP);

    load_cfg(99, 100, 4, 1'b1);
    check("R6 err cleared", cfg_err, 0);
    expect_fp(16 * 100 + 99, "R2 a99 n100");
    check("R4 pair narrow", pair_wide, 0);
    measure_fr(gap);
    check("R5 fr R=4", gap, 4 * REF_STEP);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule